// File: doc/BRIEF.md
# Cascaded Interval Interrupt Timer

This block produces two periodic, sticky interrupt requests for a small microcontroller. A 16-bit down-counting divider turns the system clock into a base tick. A second 8-bit divider, advanced only by that base tick, produces a slower tick. Each tick drives its own 7-bit interval counter. When a counter expires, it sets its interrupt flag and starts a new interval.

Software programs the timer through a plain register bus with an address, a write strobe, a read strobe, write data and combinational read data. The register map is:

| Address | Contents |
|---|---|
| 0 | Prescale value P, low byte |
| 1 | Prescale value P, high byte |
| 2 | Base divider H |
| 3 | Fast interval register |
| 4 | Slow interval register |

Any other address reads as zero.

In each interval register, bit 7 selects how a write takes effect. A 1 in bit 7 reloads the running counter at once. A 0 in bit 7 stores the new count, and the counter picks it up at its next expiry. Reading an interval register acknowledges, and so clears, that channel's interrupt flag.

Top module: `itimer_top`

## Requirements
- R1: The fast flag `irq_ms` sets once every (N+1)·(P+1) clock cycles. P is {addr 1, addr 0} and N is bits 6..0 of address 3.
- R2: The slow flag `irq_sec` sets once every (S+1)·(H+1)·(P+1) clock cycles. H is address 2 and S is bits 6..0 of address 4.
- R3: After reset, the registers read as follows: P = 999 (address 0 reads 0xE7, address 1 reads 0x03), H = 99 (0x63), and both interval registers read 0x7F. Both flags are 0. After that, every register reads back the value last written to it.
- R4: An interval register reads 0 in bit 7 and the stored count, not the live counter, in bits 6..0.
- R5: An interval write with bit 7 = 0 leaves the running count untouched. The new count applies from the next expiry onward.
- R6: An interval write with bit 7 = 1 loads the counter with the new count on that write's clock edge.
- R7: A read strobe at address 3 (or 4) clears `irq_ms` (or `irq_sec`), unless that channel expires in the same cycle.
- R8: When an expiry and a clearing read fall in the same cycle, the flag ends that cycle set.
- R9: A prescale or base-divider value written while its divider is counting takes effect at that divider's next reload. The count already in progress finishes with the old value.
- R10: A set flag stays set until a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; clears the flag of the addressed interval channel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| irq_ms | output | 1 | Sticky fast-interval interrupt flag |
| irq_sec | output | 1 | Sticky slow-interval interrupt flag |

## Verification
Two events can land on the same clock edge for one channel:
- an acknowledge read and a counter expiry;
- an immediate reload write and a tick.

The first is forced by setting P = 0 and a zero interval, so the channel expires on every cycle, and then holding the read strobe for several cycles. The flag must stay high after each of those edges. Random traffic mixes both kinds of interval write with reads and divider changes. A cycle-level model, built from the requirements, predicts both flags and every read value. Directed interval measurements confirm the period formulas and show that a deferred write does not disturb the count in progress.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    localparam int DATA_W = 8;
    localparam int PRE_W  = 16;
    localparam int DIV_W  = 8;
    localparam int IVL_W  = 7;
    localparam int ADDR_W = 3;
    localparam int NUM_CH = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_PRE_LO   = 3'd0,
        ADR_PRE_HI   = 3'd1,
        ADR_BASE_DIV = 3'd2,
        ADR_FAST_IVL = 3'd3,
        ADR_SLOW_IVL = 3'd4
    } reg_addr_e;

    // Interval register write word: load-now control above the count.
    typedef struct packed {
        logic             now;
        logic [IVL_W-1:0] count;
    } ivl_word_t;

    function automatic logic [ADDR_W-1:0] ivl_addr(input int ch);
        return ADDR_W'(int'(ADR_FAST_IVL) + ch);
    endfunction

    function automatic logic [DATA_W-1:0] ivl_readback(input logic [IVL_W-1:0] c);
        return {{(DATA_W-IVL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/itimer_divider.sv
module itimer_divider #(
    parameter int             W       = 16,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] reload,
    output logic         tick
);

    logic [W-1:0] cnt_q;

    assign tick = en && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RST_VAL;
        end else if (en) begin
            cnt_q <= tick ? reload : cnt_q - 1'b1;
        end
    end

    // R9
    reload_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_q == $past(reload));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));

endmodule

// File: rtl/itimer_interval.sv
module itimer_interval #(
    parameter int           W       = 7,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr,
    input  logic         wr_now,
    input  logic [W-1:0] wr_val,
    input  logic         rd_clr,
    output logic [W-1:0] ivl,
    output logic         flag
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] ivl_q;
    logic         flag_q;
    logic         expire;

    assign expire = tick && (cnt_q == '0);
    assign ivl    = ivl_q;
    assign flag   = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= RST_VAL;
            ivl_q  <= RST_VAL;
            flag_q <= 1'b0;
        end else begin
            if (wr) begin
                ivl_q <= wr_val;
            end
            if (wr && wr_now) begin
                cnt_q <= wr_val;
            end else if (tick) begin
                cnt_q <= expire ? ivl_q : cnt_q - 1'b1;
            end
            if (expire) begin
                flag_q <= 1'b1;
            end else if (rd_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_clr && !expire |=> !flag);

    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag && !rd_clr |=> flag);

    // R6
    immediate_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr && wr_now |=> cnt_q == $past(wr_val));

    // R5
    deferred_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr && !wr_now && tick && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R5
    reload_old_chk: assert property (@(posedge clk) disable iff (rst)
        expire && !(wr && wr_now) |=> cnt_q == $past(ivl_q));

endmodule

// File: rtl/itimer_top.sv
module itimer_top
    import itimer_pkg::*;
#(
    parameter logic [PRE_W-1:0] PRESCALE_RST = 16'd999,
    parameter logic [DIV_W-1:0] BASEDIV_RST  = 8'd99,
    parameter logic [IVL_W-1:0] IVL_RST      = 7'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_ms,
    output logic              irq_sec
);

    logic [PRE_W-1:0]  pre_q;
    logic [DIV_W-1:0]  div_q;
    logic              ms_tick;
    logic              base_tick;
    logic [NUM_CH-1:0] ch_tick;
    logic [NUM_CH-1:0] ch_flag;
    logic [IVL_W-1:0]  ch_ivl [NUM_CH];
    ivl_word_t         wr_word;

    assign wr_word = ivl_word_t'(wdata);

    // Divider reload registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= PRESCALE_RST;
            div_q <= BASEDIV_RST;
        end else if (wr_en) begin
            case (addr)
                ADR_PRE_LO:   pre_q[DATA_W-1:0]     <= wdata;
                ADR_PRE_HI:   pre_q[PRE_W-1:DATA_W] <= wdata;
                ADR_BASE_DIV: div_q                 <= wdata;
                default: ;
            endcase
        end
    end

    itimer_divider #(.W(PRE_W), .RST_VAL(PRESCALE_RST)) u_ms_div (
        .clk    (clk),
        .rst    (rst),
        .en     (1'b1),
        .reload (pre_q),
        .tick   (ms_tick)
    );

    itimer_divider #(.W(DIV_W), .RST_VAL(BASEDIV_RST)) u_base_div (
        .clk    (clk),
        .rst    (rst),
        .en     (ms_tick),
        .reload (div_q),
        .tick   (base_tick)
    );

    assign ch_tick = {base_tick, ms_tick};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = (addr == ivl_addr(g));

        itimer_interval #(.W(IVL_W), .RST_VAL(IVL_RST)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .tick   (ch_tick[g]),
            .wr     (wr_en && sel),
            .wr_now (wr_word.now),
            .wr_val (wr_word.count),
            .rd_clr (rd_en && sel),
            .ivl    (ch_ivl[g]),
            .flag   (ch_flag[g])
        );
    end

    always_comb begin
        case (addr)
            ADR_PRE_LO:   rdata = pre_q[DATA_W-1:0];
            ADR_PRE_HI:   rdata = pre_q[PRE_W-1:DATA_W];
            ADR_BASE_DIV: rdata = div_q;
            ADR_FAST_IVL: rdata = ivl_readback(ch_ivl[0]);
            ADR_SLOW_IVL: rdata = ivl_readback(ch_ivl[1]);
            default:      rdata = '0;
        endcase
    end

    assign irq_ms  = ch_flag[0];
    assign irq_sec = ch_flag[1];

    // R4
    ivl_msb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == ADR_FAST_IVL || addr == ADR_SLOW_IVL) |-> !rdata[DATA_W-1]);

    // R2
    base_nested_chk: assert property (@(posedge clk) disable iff (rst)
        base_tick |-> ms_tick);

    // R3
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pre_q == PRESCALE_RST) && (div_q == BASEDIV_RST) && !irq_ms && !irq_sec);

endmodule

// File: tb/itimer_top_bench.sv
module itimer_top_bench;

    localparam logic [2:0] A_PLO = 3'd0;
    localparam logic [2:0] A_PHI = 3'd1;
    localparam logic [2:0] A_DIV = 3'd2;
    localparam logic [2:0] A_MS  = 3'd3;
    localparam logic [2:0] A_SEC = 3'd4;
    localparam logic [15:0] P_RST = 16'd999;
    localparam logic [7:0]  H_RST = 8'd99;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_ms;
    logic       irq_sec;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    run_chk = 1'b0;
    string phase = "";

    always #5 clk = ~clk;

    itimer_top u_itimer_top (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_ms  (irq_ms),
        .irq_sec (irq_sec)
    );

    // Reference model built from the requirements
    logic [15:0]      m_pre, m_pc;
    logic [7:0]       m_div, m_hc;
    logic [1:0][6:0]  m_cnt, m_ivl;
    logic [1:0]       m_flag;
    logic             m_mt, m_ht, m_exp;
    logic [1:0]       m_tk;

    always @(posedge clk) begin
        if (rst) begin
            m_pre  <= P_RST;  m_pc <= P_RST;
            m_div  <= H_RST;  m_hc <= H_RST;
            m_cnt  <= {2{7'h7F}};
            m_ivl  <= {2{7'h7F}};
            m_flag <= 2'b00;
        end else begin
            m_mt = (m_pc == 16'd0);
            m_ht = m_mt && (m_hc == 8'd0);
            m_tk = {m_ht, m_mt};
            m_pc <= m_mt ? m_pre : m_pc - 16'd1;
            if (m_mt) m_hc <= m_ht ? m_div : m_hc - 8'd1;
            for (int ch = 0; ch < 2; ch++) begin
                m_exp = m_tk[ch] && (m_cnt[ch] == 7'd0);
                if (wr_en && addr == 3'(3 + ch) && wdata[7]) m_cnt[ch] <= wdata[6:0];
                else if (m_tk[ch]) m_cnt[ch] <= m_exp ? m_ivl[ch] : m_cnt[ch] - 7'd1;
                if (wr_en && addr == 3'(3 + ch)) m_ivl[ch] <= wdata[6:0];
                if (m_exp) m_flag[ch] <= 1'b1;
                else if (rd_en && addr == 3'(3 + ch)) m_flag[ch] <= 1'b0;
            end
            if (wr_en) begin
                case (addr)
                    A_PLO: m_pre[7:0]  <= wdata;
                    A_PHI: m_pre[15:8] <= wdata;
                    A_DIV: m_div       <= wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            A_PLO:   return m_pre[7:0];
            A_PHI:   return m_pre[15:8];
            A_DIV:   return m_div;
            A_MS:    return {1'b0, m_ivl[0]};
            A_SEC:   return {1'b0, m_ivl[1]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic cur_irq(input int ch);
        return (ch != 0) ? irq_sec : irq_ms;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // Per-cycle flag comparison (R1 fast channel, R2 slow channel)
    always @(negedge clk) begin
        if (!rst && run_chk) begin
            check((phase == "") ? "R1" : phase, int'(irq_ms),  int'(m_flag[0]));
            check((phase == "") ? "R2" : phase, int'(irq_sec), int'(m_flag[1]));
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, int'(rdata), int'(exp_rd(a)));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Returns edges from acknowledge read to next set: period minus 2
    task automatic measure(input int ch, output int n);
        while (!cur_irq(ch)) @(negedge clk);
        bus_read(3'(3 + ch), phase);
        n = 0;
        while (!cur_irq(ch)) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d cycles", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240613));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        run_chk = 1'b1;

        // R3: reset state
        phase = "R3";
        check("R3", int'(irq_ms), 0);
        check("R3", int'(irq_sec), 0);
        bus_read(A_PLO, "R3");
        bus_read(A_PHI, "R3");
        bus_read(A_DIV, "R3");
        bus_read(A_MS,  "R3");
        bus_read(A_SEC, "R3");

        // R4: control bit never reads back
        phase = "R4";
        bus_write(A_MS, 8'hC5);
        bus_read(A_MS, "R4");
        bus_write(A_SEC, 8'hFE);
        bus_read(A_SEC, "R4");

        // R9: new prescale waits for the running count
        phase = "R9";
        bus_write(A_PLO, 8'h00);
        bus_write(A_PHI, 8'h00);
        bus_read(A_PLO, "R9");
        repeat (1100) @(negedge clk);

        // R8: expiry every cycle, acknowledge every cycle
        phase = "R8";
        bus_write(A_MS, 8'h80);
        @(negedge clk);
        addr = A_MS; rd_en = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check("R8", int'(irq_ms), 1);
        end
        rd_en = 1'b0;

        // R7: acknowledge clears
        phase = "R7";
        bus_write(A_MS, 8'hFF);
        bus_read(A_MS, "R7");
        check("R7", int'(irq_ms), 0);

        // R10: flag holds without reads
        phase = "R10";
        repeat (200) @(negedge clk);
        check("R10", int'(irq_ms), 1);

        // R6: immediate load
        phase = "R6";
        bus_write(A_MS, 8'h83);
        bus_read(A_MS, "R6");
        n = 0;
        while (!irq_ms) begin @(negedge clk); n++; end
        check("R6", n, 2);

        // R5: deferred load keeps running count
        phase = "R5";
        bus_write(A_MS, 8'h8F);
        bus_read(A_MS, "R5");
        bus_write(A_MS, 8'h02);
        n = 0;
        while (!irq_ms) begin @(negedge clk); n++; end
        check("R5", n, 12);
        measure(0, n);
        measure(0, n);
        check("R5", n, 1);

        // R1: P=2, N=3 -> period 12
        phase = "R1";
        bus_write(A_PLO, 8'h02);
        bus_write(A_MS, 8'h83);
        measure(0, n);
        measure(0, n);
        check("R1", n, 10);

        // R2: P=0, H=2, S=1 -> period 6; P=1, H=1, S=2 -> period 12
        phase = "R2";
        bus_write(A_PLO, 8'h00);
        bus_write(A_DIV, 8'h02);
        bus_write(A_SEC, 8'h81);
        measure(1, n);
        measure(1, n);
        check("R2", n, 4);
        bus_write(A_PLO, 8'h01);
        bus_write(A_DIV, 8'h01);
        bus_write(A_SEC, 8'h82);
        measure(1, n);
        measure(1, n);
        measure(1, n);
        check("R2", n, 10);

        // Random mix of writes, reads and idles
        phase = "";
        for (int i = 0; i < 1500; i++) begin
            int op;
            logic [2:0] a;
            logic [7:0] d;
            op = int'($urandom % 10);
            a  = 3'($urandom % 5);
            case (a)
                A_PLO, A_DIV: d = 8'($urandom % 4);
                A_PHI:        d = 8'h00;
                default:      d = {1'($urandom % 2), 7'($urandom % 16)};
            endcase
            if (op < 3)      bus_write(a, d);
            else if (op < 6) bus_read(a, (a < A_MS) ? "R3" : "R4");
            else             @(negedge clk);
        end

        run_chk = 1'b0;
        summary();
        $finish;
    end

endmodule